// File: doc/BRIEF.md
# Priority-Based Pin Function Resolver

This block decides which internal signal owns each of five multi-function pins. Four writable control words and one strap word captured at reset feed a fixed table of conditions. At each priority level a pin offers one signal. That signal is enabled by the OR of one or more function terms, and each term is the AND of field comparisons. A comparison masks a field out of one control or strap word and tests it against a right-aligned value, which is moved up to the lowest set bit of the mask first. The first level whose signal is enabled wins. When no level is enabled, the pin falls back to its last "other" signal.

Software programs the control words through a plain write/read port. The resolved selection appears at once, as a 3-bit code per pin, on a flat output bus. The port has no stream traffic, so it carries no valid/ready handshake. A write lands on the clock edge where `wr_en` is high. A read returns the addressed word combinationally.

Top module: `pmx_resolver`

## Requirements
- R1: During reset and right after it, every control word reads zero and every pin shows its fallback code.
- R2: A write to offset 0x3C, 0x80, 0x84 or 0x90 updates that word on the write's clock edge, and the same offset then reads back the written value.
- R3: A write to any other offset changes no word and no pin code. A read of an offset other than the four control words and 0x70 returns zero.
- R4: The strap word reads at offset 0x70. It holds the `strap_in` value sampled at the last clock edge with `rst_n` low, and writes to 0x70 leave it unchanged.
- R5: Pin 0 shows code 0 (external reset) when 0x3C bit 3 = 1, 0x80 bit 15 = 1 and 0x90 bit 31 = 0.
- R6: Pin 0 shows code 1 (SPI chip-select) when 0x3C bit 3 = 1, 0x80 bit 15 = 1 and 0x90 bit 31 = 1. Otherwise it shows code 2.
- R7: Pin 1 shows code 0 (video data-enable) when 0x90 bits [5:4] are nonzero (01 18-bit, 10 24-bit, 11 30-bit video) and 0x84 bit 17 = 1. With bits [5:4] = 00 and bit 17 = 1 it shows code 1 (UART carrier-detect). Otherwise it shows code 2.
- R8: Pins 2 and 3 use 0x84 bits 22 and 23 respectively. With the pin's bit set, the pin shows code 0 (video data bit) only when 0x90 bits [5:4] = 11, and code 1 (UART TX/RX) otherwise. With the bit clear, it shows code 2.
- R9: Pin 4 shows code 0 when 0x80 bit 12 = 1 or strap bit 14 = 1. Otherwise it shows its fallback code 1.
- R10: Each pin's code is the index of the winning level (0 is highest priority). The fallback code equals the number of levels the pin defines: 2 for pins 0 to 3 and 1 for pin 4. Pin p occupies `pin_sel[3p+2:3p]`.
- R11: A lower level never wins while a higher level on the same pin is enabled, even when both are enabled by a shared bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap sampled while low |
| strap_in | input | 32 | Strap value captured during reset |
| wr_en | input | 1 | Write strobe for the control words |
| addr | input | 8 | Byte offset for write and read |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| pin_sel | output | 15 | Five 3-bit per-pin level codes |

## Verification
The hardest state to reach is one where two priority levels on a pin are enabled by a shared bit, with a multi-bit mode field choosing between them. One example is 0x84 bit 17 set while 0x90 [5:4] steps through every mode. Another is a data pin whose bit is set while the mode is any value other than 11. A table of directed vectors places the shared bit and each mode value side by side. Random control and strap values are then checked against an independent per-pin evaluation across several resets, each with a different strap. The strap's OR term on pin 4 is only reachable by changing `strap_in` across a reset, and a directed reset covers it.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int DW       = 32;
  localparam int AW       = 8;
  localparam int NUM_PINS = 5;
  localparam int MAX_LVL  = 4;
  localparam int MAX_EXPR = 3;
  localparam int MAX_DESC = 3;
  localparam int NSRC     = 5;
  localparam int CODE_W   = $clog2(MAX_LVL + 1);

  localparam logic [AW-1:0] OFF_SYS   = 8'h3C;
  localparam logic [AW-1:0] OFF_A     = 8'h80;
  localparam logic [AW-1:0] OFF_B     = 8'h84;
  localparam logic [AW-1:0] OFF_E     = 8'h90;
  localparam logic [AW-1:0] OFF_STRAP = 8'h70;

  localparam logic [2:0] SRC_SYS   = 3'd0;
  localparam logic [2:0] SRC_A     = 3'd1;
  localparam logic [2:0] SRC_B     = 3'd2;
  localparam logic [2:0] SRC_E     = 3'd3;
  localparam logic [2:0] SRC_STRAP = 3'd4;

  typedef struct packed {
    logic          used;
    logic [2:0]    src;
    logic [DW-1:0] mask;
    logic [DW-1:0] val;   // right-aligned compare value
  } desc_t;

  function automatic desc_t mk(logic [2:0] src, logic [DW-1:0] mask, logic [DW-1:0] val);
    desc_t r;
    r.used = 1'b1;
    r.src  = src;
    r.mask = mask;
    r.val  = val;
    return r;
  endfunction

  function automatic int lsb_pos(logic [DW-1:0] mask);
    int pos = 0;
    for (int i = DW - 1; i >= 0; i--)
      if (mask[i]) pos = i;
    return pos;
  endfunction

  function automatic int pin_levels(int p);
    return (p < 4) ? 2 : 1;
  endfunction

  function automatic logic is_rw_off(logic [AW-1:0] a);
    return (a == OFF_SYS) || (a == OFF_A) || (a == OFF_B) || (a == OFF_E);
  endfunction

  // Condition table: pin, level, OR-term, AND-descriptor
  function automatic desc_t desc_at(int p, int l, int e, int d);
    desc_t r;
    r = '0;
    case (p)
      0: if (l < 2 && e == 0)
           case (d)
             0: r = mk(SRC_SYS, 32'h0000_0008, 32'd1);
             1: r = mk(SRC_A,   32'h0000_8000, 32'd1);
             2: r = mk(SRC_E,   32'h8000_0000, (l == 0) ? 32'd0 : 32'd1);
             default: r = '0;
           endcase
      1: if (l == 0)
           case (d)
             0: r = mk(SRC_E, 32'h0000_0030, 32'(e + 1));
             1: r = mk(SRC_B, 32'h0002_0000, 32'd1);
             default: r = '0;
           endcase
         else if (l == 1 && e == 0 && d == 0)
           r = mk(SRC_B, 32'h0002_0000, 32'd1);
      2, 3: if (l == 0 && e == 0)
           case (d)
             0: r = mk(SRC_E, 32'h0000_0030, 32'd3);
             1: r = mk(SRC_B, (p == 2) ? 32'h0040_0000 : 32'h0080_0000, 32'd1);
             default: r = '0;
           endcase
         else if (l == 1 && e == 0 && d == 0)
           r = mk(SRC_B, (p == 2) ? 32'h0040_0000 : 32'h0080_0000, 32'd1);
      4: if (l == 0 && d == 0) begin
           if (e == 0) r = mk(SRC_A, 32'h0000_1000, 32'd1);
           else if (e == 1) r = mk(SRC_STRAP, 32'h0000_4000, 32'd1);
         end
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pmx_regbank.sv
module pmx_regbank
  import pmx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DW-1:0]       strap_in,
  input  logic                wr_en,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rd_data,
  output logic [NSRC*DW-1:0]  src_words
);
  logic [DW-1:0] sys_q, a_q, b_q, e_q, strap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sys_q   <= '0;
      a_q     <= '0;
      b_q     <= '0;
      e_q     <= '0;
      strap_q <= strap_in;
    end else if (wr_en) begin
      if (addr == OFF_SYS) sys_q <= wdata;
      if (addr == OFF_A)   a_q   <= wdata;
      if (addr == OFF_B)   b_q   <= wdata;
      if (addr == OFF_E)   e_q   <= wdata;
    end
  end

  always_comb begin
    case (addr)
      OFF_SYS:   rd_data = sys_q;
      OFF_A:     rd_data = a_q;
      OFF_B:     rd_data = b_q;
      OFF_E:     rd_data = e_q;
      OFF_STRAP: rd_data = strap_q;
      default:   rd_data = '0;
    endcase
  end

  assign src_words = {strap_q, e_q, b_q, a_q, sys_q};
endmodule

// File: rtl/pmx_desc_match.sv
module pmx_desc_match
  import pmx_pkg::*;
#(
  parameter logic [DW-1:0] MASK = 32'h1,
  parameter logic [DW-1:0] VAL  = 32'h1
) (
  input  logic [DW-1:0] word,
  output logic          hit
);
  localparam int            SHIFT = lsb_pos(MASK);
  localparam logic [DW-1:0] POSV  = VAL << SHIFT;

  assign hit = ((word & MASK) == POSV);
endmodule

// File: rtl/pmx_pin_resolve.sv
module pmx_pin_resolve
  import pmx_pkg::*;
#(
  parameter int PIN = 0
) (
  input  logic [NSRC*DW-1:0] src_words,
  output logic [CODE_W-1:0]  code
);
  localparam int NLVL = pin_levels(PIN);

  logic [MAX_LVL-1:0] lvl_hit;
  logic               unused_words;
  assign unused_words = ^src_words;

  for (genvar l = 0; l < MAX_LVL; l++) begin : g_lvl
    logic [MAX_EXPR-1:0] expr_hit;
    for (genvar e = 0; e < MAX_EXPR; e++) begin : g_expr
      logic [MAX_DESC-1:0] d_hit;
      for (genvar d = 0; d < MAX_DESC; d++) begin : g_desc
        localparam desc_t D = desc_at(PIN, l, e, d);
        if (D.used) begin : g_on
          pmx_desc_match #(.MASK(D.mask), .VAL(D.val)) u_match (
            .word (src_words[int'(D.src)*DW +: DW]),
            .hit  (d_hit[d])
          );
        end else begin : g_off
          assign d_hit[d] = 1'b1;
        end
      end
      localparam desc_t D0 = desc_at(PIN, l, e, 0);
      if (D0.used) begin : g_term
        assign expr_hit[e] = &d_hit;
      end else begin : g_noterm
        assign expr_hit[e] = 1'b0;
      end
    end
    assign lvl_hit[l] = |expr_hit;
  end

  always_comb begin
    code = CODE_W'(NLVL);
    for (int l = MAX_LVL - 1; l >= 0; l--)
      if (lvl_hit[l]) code = CODE_W'(l);
  end
endmodule

// File: rtl/pmx_resolver.sv
module pmx_resolver
  import pmx_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [31:0]                  strap_in,
  input  logic                         wr_en,
  input  logic [7:0]                   addr,
  input  logic [31:0]                  wdata,
  output logic [31:0]                  rd_data,
  output logic [14:0]                  pin_sel
);
  logic [NSRC*DW-1:0] src_words;

  pmx_regbank u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_in  (strap_in),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rd_data   (rd_data),
    .src_words (src_words)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pmx_pin_resolve #(.PIN(p)) u_pin (
      .src_words (src_words),
      .code      (pin_sel[p*CODE_W +: CODE_W])
    );
  end
endmodule

// File: rtl/pmx_resolver_chk.sv
module pmx_resolver_chk
  import pmx_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [7:0]  addr,
  input logic [31:0] wdata,
  input logic [31:0] rd_data,
  input logic [14:0] pin_sel,
  input logic [31:0] w_sys,
  input logic [31:0] w_a,
  input logic [31:0] w_e,
  input logic [31:0] w_strap
);
  // R10: code never exceeds the pin's fallback index
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_rng
    p_code_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pin_sel[p*CODE_W +: CODE_W] <= CODE_W'(pin_levels(p)));
  end

  // R3: undefined offsets read zero
  p_undef_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_rw_off(addr) && addr != OFF_STRAP) |-> rd_data == 32'd0);

  // R2: written word reads back while the address is held
  p_write_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_rw_off(addr)) |=> (!$stable(addr) || rd_data == $past(wdata)));

  // R4: strap word is frozen outside reset
  p_strap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(w_strap));

  // R6: shared enables plus select bit give the chip-select level
  p_spi_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (w_sys[3] && w_a[15] && w_e[31]) |-> pin_sel[2:0] == 3'd1);

  // R8: data-bit pin high level needs 30-bit mode
  p_mode3_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_sel[8:6] == 3'd0) |-> w_e[5:4] == 2'b11);

  // R9: OR of control bit and strap bit
  p_orpin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (w_a[12] || w_strap[14]) == (pin_sel[14:12] == 3'd0));
endmodule

bind pmx_resolver pmx_resolver_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .rd_data (rd_data),
  .pin_sel (pin_sel),
  .w_sys   (src_words[0 +: 32]),
  .w_a     (src_words[32 +: 32]),
  .w_e     (src_words[96 +: 32]),
  .w_strap (src_words[128 +: 32])
);

// File: tb/pmx_resolver_tb.sv
module pmx_resolver_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] strap_in = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [14:0] pin_sel;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pmx_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data), .pin_sel(pin_sel)
  );

  typedef struct packed {
    logic [31:0] sys, a, b, e;
    logic [14:0] exp;
  } vec_t;

  // exp = {p4,p3,p2,p1,p0}, strap = 0
  localparam vec_t VECS [10] = '{
    '{32'h0, 32'h0,    32'h0,        32'h0,         {3'd1,3'd2,3'd2,3'd2,3'd2}},
    '{32'h8, 32'h8000, 32'h0,        32'h0,         {3'd1,3'd2,3'd2,3'd2,3'd0}},
    '{32'h8, 32'h8000, 32'h0,        32'h8000_0000, {3'd1,3'd2,3'd2,3'd2,3'd1}},
    '{32'h0, 32'h8000, 32'h0,        32'h8000_0000, {3'd1,3'd2,3'd2,3'd2,3'd2}},
    '{32'h0, 32'h0,    32'h0002_0000, 32'h0,        {3'd1,3'd2,3'd2,3'd1,3'd2}},
    '{32'h0, 32'h0,    32'h0002_0000, 32'h10,       {3'd1,3'd2,3'd2,3'd0,3'd2}},
    '{32'h0, 32'h0,    32'h00C0_0000, 32'h20,       {3'd1,3'd1,3'd1,3'd2,3'd2}},
    '{32'h0, 32'h0,    32'h00C2_0000, 32'h30,       {3'd1,3'd0,3'd0,3'd0,3'd2}},
    '{32'h0, 32'h1000, 32'h0,        32'h0,         {3'd0,3'd2,3'd2,3'd2,3'd2}},
    '{32'h0, 32'h0,    32'h0040_0000, 32'h30,       {3'd1,3'd2,3'd0,3'd2,3'd2}}
  };

  function automatic logic [14:0] ref_codes(logic [31:0] s, logic [31:0] a,
                                            logic [31:0] b, logic [31:0] e,
                                            logic [31:0] st);
    logic [2:0] c0, c1, c2, c3, c4;
    c0 = (s[3] && a[15]) ? (e[31] ? 3'd1 : 3'd0) : 3'd2;
    c1 = b[17] ? ((e[5:4] != 2'b00) ? 3'd0 : 3'd1) : 3'd2;
    c2 = b[22] ? ((e[5:4] == 2'b11) ? 3'd0 : 3'd1) : 3'd2;
    c3 = b[23] ? ((e[5:4] == 2'b11) ? 3'd0 : 3'd1) : 3'd2;
    c4 = (a[12] || st[14]) ? 3'd0 : 3'd1;
    return {c4, c3, c2, c1, c0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic load(input logic [31:0] s, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] e);
    wr(8'h3C, s); wr(8'h80, a); wr(8'h84, b); wr(8'h90, e);
  endtask

  task automatic do_reset(input logic [31:0] st);
    @(negedge clk);
    rst_n = 1'b0; strap_in = st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    strap_in = ~st;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] st;
    do_reset(32'h0);

    // R1: reset state
    rd(8'h3C, d); chk(d == 0, "R1 sys word", d, 0);
    rd(8'h90, d); chk(d == 0, "R1 mode word", d, 0);
    chk(pin_sel == {3'd1,3'd2,3'd2,3'd2,3'd2}, "R1 fallback codes", 32'(pin_sel),
        32'({3'd1,3'd2,3'd2,3'd2,3'd2}));

    // R5 R6 R7 R8 R9 R10 R11: directed vector table
    foreach (VECS[i]) begin
      load(VECS[i].sys, VECS[i].a, VECS[i].b, VECS[i].e);
      #1 chk(pin_sel == VECS[i].exp, $sformatf("R5-vector%0d R6 R7 R8 R9 R10 R11", i),
             32'(pin_sel), 32'(VECS[i].exp));
    end

    // R7: every mode value with shared bit 17
    for (int m = 0; m < 4; m++) begin
      load(32'h0, 32'h0, 32'h0002_0000, 32'(m) << 4);
      #1 chk(pin_sel[5:3] == ((m != 0) ? 3'd0 : 3'd1), "R7 mode sweep",
             32'(pin_sel[5:3]), (m != 0) ? 0 : 1);
    end

    // R2: readback
    wr(8'h84, 32'hA5A5_1234);
    rd(8'h84, d); chk(d == 32'hA5A5_1234, "R2 readback", d, 32'hA5A5_1234);

    // R3: undefined offset write ignored, reads zero
    load(32'h8, 32'h8000, 32'h0, 32'h0);
    wr(8'h88, 32'hFFFF_FFFF);
    rd(8'h88, d); chk(d == 0, "R3 undefined read", d, 0);
    rd(8'h90, d); chk(d == 0, "R3 neighbour untouched", d, 0);
    chk(pin_sel[2:0] == 3'd0, "R3 pin code unchanged", 32'(pin_sel[2:0]), 0);

    // R4: strap capture and write ignored
    do_reset(32'h0000_4000);
    rd(8'h70, d); chk(d == 32'h0000_4000, "R4 strap capture", d, 32'h4000);
    chk(pin_sel[14:12] == 3'd0, "R9 strap term", 32'(pin_sel[14:12]), 0);
    wr(8'h70, 32'h0);
    rd(8'h70, d); chk(d == 32'h0000_4000, "R4 strap write ignored", d, 32'h4000);
    chk(pin_sel[14:12] == 3'd0, "R4 pin4 after strap write", 32'(pin_sel[14:12]), 0);

    // R11: random sweep against reference, several straps
    for (int r = 0; r < 4; r++) begin
      st = $urandom;
      do_reset(st);
      for (int k = 0; k < 50; k++) begin
        logic [31:0] s, a, b, e;
        s = $urandom; a = $urandom; b = $urandom; e = $urandom;
        load(s, a, b, e);
        #1 chk(pin_sel == ref_codes(s, a, b, e, st), "R11 random priority",
               32'(pin_sel), 32'(ref_codes(s, a, b, e, st)));
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule